// File: doc/BRIEF.md
# Shared Prescaled 64-bit Time Base

This block keeps one 64-bit up-counter that every processor in a cluster sees as the same time value. It counts input clocks through a programmable divider. A run bit and an 8-bit divide field, both in a control word, set when it counts and how fast. Software reaches it through a plain request port: a valid strobe, a write flag, a byte address inside a 32-byte window, and 32-bit write data. Read data returns one cycle later with a valid flag.

The counter appears as two 32-bit words. Software may load it word by word, but only while counting is stopped. The full 64-bit value and a single-cycle advance pulse go out to the per-processor compare banks that sit beside this block. Those banks also supply their own control bits, and a control read merges them in. Addresses that this block does not decode, and addresses that are not word-aligned, read as zero and ignore writes.

Top module: `glbl_count_top`

## Requirements
- R1: A read request (valid high, write low) in one cycle gives rd_valid_o high in the next cycle, with rd_data_o holding the addressed word as it was in the request cycle. The low counter word is at offset 0x00, the high word at 0x04 and control at 0x08. With no read request, rd_valid_o is low in the next cycle.
- R2: While the run bit (control bit 0) is set, count_o rises by one once every P+1 clocks, where P is control bits 15:8. tick_o is high in exactly those cycles after which count_o rises at the next edge.
- R3: While the run bit is clear, tick_o stays low and count_o holds its value unless a counter word is written.
- R4: A write to offset 0x00 or 0x04 while the run bit is set has no effect on count_o.
- R5: While stopped, a write to 0x00 replaces count_o bits 31:0 and a write to 0x04 replaces bits 63:32. The other word is kept, and the new value shows on count_o in the cycle after the write.
- R6: A control read returns the run bit at bit 0 and the divide field at bits 15:8, with all other stored bits zero, ORed bitwise with banked_ctrl_i.
- R7: After reset, count_o is zero, the control word is zero, tick_o is low and rd_valid_o is low.
- R8: A control write that changes the run bit or the divide field restarts the divider. The first tick_o then comes in the (P+1)th cycle after the write edge. A control write that leaves both unchanged does not disturb the divider phase.
- R9: Reads at offsets 0x0C to 0x1C, and at any address with bits 1:0 nonzero, return zero. Writes there change neither the counter nor the control word.
- R10: count_o wraps from all ones to zero on an advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 5 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| banked_ctrl_i | input | 32 | Control bits of the accessing processor, merged on control reads |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| rd_data_o | output | 32 | Read data |
| count_o | output | 64 | Current counter value |
| tick_o | output | 1 | High in a cycle whose closing edge advances the counter |

## Verification
A divider phase that drifts shows up as a tick_o pulse that is early or late against the expected period, within P+1 cycles of the error. A count that loses or gains a value differs on count_o at the very next edge. Because the bench follows the counter, divider and control state every cycle, a wrongly accepted counter write while running, or an unaligned access that is decoded by mistake, shows as a count_o mismatch one cycle after the request. A read-mux fault shows on the single cycle where rd_valid_o is high.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned ADDR_W    = 5;
    localparam int unsigned CNT_WORDS = 2;
    localparam int unsigned CNT_W     = WORD_W * CNT_WORDS;
    localparam int unsigned PS_W      = 8;
    localparam int unsigned PS_LSB    = 8;
    localparam int unsigned EN_BIT    = 0;
    localparam int unsigned IDX_W     = ADDR_W - 2;

    // control word lives right after the counter words
    localparam int unsigned CTRL_IDX  = CNT_WORDS;

    typedef struct packed {
        logic            en;
        logic [PS_W-1:0] ps;
    } ctrl_t;

    function automatic logic [WORD_W-1:0] pack_ctrl(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[EN_BIT] = c.en;
        w[PS_LSB +: PS_W] = c.ps;
        return w;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.en = w[EN_BIT];
        c.ps = w[PS_LSB +: PS_W];
        return c;
    endfunction

endpackage

// File: rtl/gcnt_regif.sv
module gcnt_regif
    import gcnt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [WORD_W-1:0]    req_wdata,
    input  logic [WORD_W-1:0]    banked_ctrl,
    input  logic [CNT_W-1:0]     count,
    output ctrl_t                ctrl,
    output logic                 ctrl_changed,
    output logic [CNT_WORDS-1:0] word_wr,
    output logic                 rd_valid,
    output logic [WORD_W-1:0]    rd_data
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic              rd_valid;
        logic [WORD_W-1:0] rd_data;
    } regif_st_t;

    regif_st_t st_d, st_q;

    logic             aligned;
    logic [IDX_W-1:0] idx;
    logic             is_cnt;
    logic             is_ctrl;
    logic             wr_fire;
    logic             rd_fire;
    ctrl_t            new_ctrl;
    logic [WORD_W-1:0] rd_mux;

    always_comb begin
        aligned  = (req_addr[1:0] == 2'b00);
        idx      = req_addr[ADDR_W-1:2];
        is_cnt   = aligned && (idx < IDX_W'(CNT_WORDS));
        is_ctrl  = aligned && (idx == IDX_W'(CTRL_IDX));
        wr_fire  = req_valid && req_write;
        rd_fire  = req_valid && !req_write;
        new_ctrl = unpack_ctrl(req_wdata);

        for (int w = 0; w < CNT_WORDS; w++) begin
            word_wr[w] = wr_fire && aligned && (idx == IDX_W'(w));
        end

        rd_mux = '0;
        if (is_cnt) begin
            for (int w = 0; w < CNT_WORDS; w++) begin
                if (idx == IDX_W'(w)) begin
                    rd_mux = count[w*WORD_W +: WORD_W];
                end
            end
        end else if (is_ctrl) begin
            rd_mux = pack_ctrl(st_q.ctrl) | banked_ctrl;
        end

        ctrl_changed = wr_fire && is_ctrl && (new_ctrl != st_q.ctrl);

        st_d          = st_q;
        st_d.rd_valid = rd_fire;
        st_d.rd_data  = rd_fire ? rd_mux : '0;
        if (wr_fire && is_ctrl) begin
            st_d.ctrl = new_ctrl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl     = st_q.ctrl;
    assign rd_valid = st_q.rd_valid;
    assign rd_data  = st_q.rd_data;

endmodule

// File: rtl/gcnt_divider.sv
module gcnt_divider #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] ps,
    input  logic             restart,
    output logic             adv
);

    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        adv  = en && (st_q.phase == ps);
        st_d = st_q;
        if (restart || !en || adv) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gcnt_counter.sv
module gcnt_counter #(
    parameter int unsigned SEG_W = 32,
    parameter int unsigned SEGS  = 2,
    localparam int unsigned TOT_W = SEG_W * SEGS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             en,
    input  logic [SEGS-1:0]  seg_wr,
    input  logic [SEG_W-1:0] wdata,
    output logic [TOT_W-1:0] value
);

    typedef struct packed {
        logic [TOT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.cnt = st_q.cnt + TOT_W'(1);
        end
        if (!en) begin
            for (int s = 0; s < SEGS; s++) begin
                if (seg_wr[s]) begin
                    st_d.cnt[s*SEG_W +: SEG_W] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.cnt;

endmodule

// File: rtl/glbl_count_top.sv
module glbl_count_top
    import gcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [4:0]        req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [31:0]       banked_ctrl_i,
    output logic              rd_valid_o,
    output logic [31:0]       rd_data_o,
    output logic [63:0]       count_o,
    output logic              tick_o
);

    ctrl_t                ctrl;
    logic                 ctrl_changed;
    logic [CNT_WORDS-1:0] word_wr;
    logic                 adv;
    logic                 timer_en;
    logic [CNT_W-1:0]     count;

    assign timer_en = ctrl.en;

    gcnt_regif u_regif (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .banked_ctrl  (banked_ctrl_i),
        .count        (count),
        .ctrl         (ctrl),
        .ctrl_changed (ctrl_changed),
        .word_wr      (word_wr),
        .rd_valid     (rd_valid_o),
        .rd_data      (rd_data_o)
    );

    gcnt_divider #(.DIV_W(PS_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl.en),
        .ps      (ctrl.ps),
        .restart (ctrl_changed),
        .adv     (adv)
    );

    gcnt_counter #(.SEG_W(WORD_W), .SEGS(CNT_WORDS)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .en     (ctrl.en),
        .seg_wr (word_wr),
        .wdata  (req_wdata),
        .value  (count)
    );

    assign count_o = count;
    assign tick_o  = adv;

endmodule

// File: rtl/gcnt_checker.sv
module gcnt_checker
    import gcnt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [CNT_W-1:0]  count_o,
    input logic              tick_o,
    input logic              rd_valid_o,
    input logic              timer_en
);

    logic cnt_wr;
    assign cnt_wr = req_valid && req_write && (req_addr[1:0] == 2'b00)
                    && (req_addr < ADDR_W'(CNT_WORDS * 4));

    // R2
    tick_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (count_o == $past(count_o) + CNT_W'(1)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_o && !cnt_wr) |=> $stable(count_o));

    // R3
    stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !timer_en |-> !tick_o);

    // R4
    run_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_en && cnt_wr && !tick_o) |=> $stable(count_o));

    // R1
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid_o);

    // R1
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid_o);

endmodule

bind glbl_count_top gcnt_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .count_o    (count_o),
    .tick_o     (tick_o),
    .rd_valid_o (rd_valid_o),
    .timer_en   (timer_en)
);

// File: tb/glbl_count_top_bench.sv
module glbl_count_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] banked_ctrl_i = '0;
    logic        rd_valid_o;
    logic [31:0] rd_data_o;
    logic [63:0] count_o;
    logic        tick_o;

    always #10 clk = ~clk;

    glbl_count_top u_glbl_count_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .banked_ctrl_i (banked_ctrl_i),
        .rd_valid_o    (rd_valid_o),
        .rd_data_o     (rd_data_o),
        .count_o       (count_o),
        .tick_o        (tick_o)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R7";
    bit    finished = 1'b0;

    // behavioural reference state
    bit [63:0] m_cnt = '0;
    bit        m_en = 1'b0;
    int        m_ps = 0;
    int        m_div = 0;
    bit        m_rdv = 1'b0;
    bit [31:0] m_rd = '0;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit adv;
        bit nen;
        int nps;
        bit restart;
        if (!rst_n) begin
            m_cnt = '0; m_en = 1'b0; m_ps = 0; m_div = 0; m_rdv = 1'b0; m_rd = '0;
        end else begin
            adv = m_en && (m_div == m_ps);
            m_rdv = req_valid && !req_write;
            m_rd = '0;
            if (m_rdv) begin
                case (req_addr)
                    5'h00: m_rd = m_cnt[31:0];
                    5'h04: m_rd = m_cnt[63:32];
                    5'h08: m_rd = ((m_ps & 32'hFF) << 8) | 32'(m_en) | banked_ctrl_i;
                    default: m_rd = '0;
                endcase
            end
            nen = m_en; nps = m_ps; restart = 1'b0;
            if (req_valid && req_write && req_addr == 5'h08) begin
                nen = req_wdata[0];
                nps = int'(req_wdata[15:8]);
                restart = (nen != m_en) || (nps != m_ps);
            end
            if (restart || !m_en || adv) m_div = 0;
            else m_div = m_div + 1;
            if (adv) m_cnt = m_cnt + 64'd1;
            if (req_valid && req_write && !m_en) begin
                if (req_addr == 5'h00) m_cnt[31:0] = req_wdata;
                if (req_addr == 5'h04) m_cnt[63:32] = req_wdata;
            end
            m_en = nen; m_ps = nps;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(cur_req, "count_o", count_o, m_cnt);
            chk(cur_req, "tick_o", 64'(tick_o), 64'(m_en && (m_div == m_ps)));
            chk("R1", "rd_valid_o", 64'(rd_valid_o), 64'(m_rdv));
            if (m_rdv) chk("R1", "rd_data_o", 64'(rd_data_o), 64'(m_rd));
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        d = rd_data_o;
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] c0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk("R7", "count after reset", count_o, 64'h0);
        chk("R7", "tick after reset", 64'(tick_o), 64'h0);
        chk("R7", "rd_valid after reset", 64'(rd_valid_o), 64'h0);
        rd(5'h08, d);
        chk("R7", "control after reset", 64'(d), 64'h0);

        cur_req = "R5";
        wr(5'h00, 32'hDEAD_BEEF);
        wr(5'h04, 32'h0000_0001);
        rd(5'h00, d); chk("R1", "low word read", 64'(d), 64'hDEAD_BEEF);
        rd(5'h04, d); chk("R1", "high word read", 64'(d), 64'h1);
        wr(5'h00, 32'h1234_5678);
        chk("R5", "low write keeps high", count_o, 64'h1_1234_5678);

        cur_req = "R6";
        banked_ctrl_i = 32'h0000_0006;
        wr(5'h08, 32'hFFFF_AB00);
        rd(5'h08, d); chk("R6", "merged control", 64'(d), 64'h0000_AB06);
        banked_ctrl_i = 32'h0;
        rd(5'h08, d); chk("R6", "global control only", 64'(d), 64'h0000_AB00);

        cur_req = "R3";
        idle(20);
        chk("R3", "stopped count holds", count_o, 64'h1_1234_5678);

        cur_req = "R9";
        wr(5'h0C, 32'h1);
        wr(5'h10, 32'h55);
        wr(5'h1C, 32'hFFFF_FFFF);
        wr(5'h01, 32'hFFFF_FFFF);
        wr(5'h09, 32'h0000_0001);
        chk("R9", "unmapped writes leave count", count_o, 64'h1_1234_5678);
        rd(5'h0C, d); chk("R9", "read 0x0C", 64'(d), 64'h0);
        rd(5'h14, d); chk("R9", "read 0x14", 64'(d), 64'h0);
        rd(5'h02, d); chk("R9", "unaligned read", 64'(d), 64'h0);
        rd(5'h08, d); chk("R9", "control untouched", 64'(d), 64'h0000_AB00);

        cur_req = "R2";
        wr(5'h08, 32'h0000_0301);
        c0 = count_o;
        idle(40);
        chk("R2", "ten advances in forty clocks", count_o, c0 + 64'd10);

        cur_req = "R8";
        idle(2);
        wr(5'h08, 32'h0000_0301);
        idle(5);
        wr(5'h08, 32'h0000_0401);
        for (int i = 1; i <= 4; i++) begin
            chk("R8", "no tick before period", 64'(tick_o), 64'h0);
            @(negedge clk);
        end
        chk("R8", "first tick after restart", 64'(tick_o), 64'h1);

        cur_req = "R4";
        wr(5'h08, 32'h0000_FF01);
        c0 = count_o;
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h0000_AAAA);
        chk("R4", "running write ignored", count_o, c0);
        rd(5'h00, d); chk("R4", "low word unchanged", 64'(d), 64'(c0[31:0]));

        cur_req = "R10";
        wr(5'h08, 32'h0);
        wr(5'h00, 32'hFFFF_FFFF);
        wr(5'h04, 32'hFFFF_FFFF);
        wr(5'h08, 32'h0000_0001);
        chk("R10", "tick at all ones", 64'(tick_o), 64'h1);
        @(negedge clk);
        chk("R10", "wrap to zero", count_o, 64'h0);

        cur_req = "R2";
        idle(10);
        wr(5'h08, 32'h0000_0101);
        idle(15);
        wr(5'h08, 32'h0);
        idle(4);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule